// File: doc/BRIEF.md
# PWM Timebase Generator

This block produces the common timebase that every channel of a multi-channel pulse-width modulator compares against. A prescaler divides the input clock into beats. Each beat lasts a programmable number of clock periods. A 16-bit phase accumulator advances once per beat. The phase is a fraction of one PWM cycle in units of 2^-16. The size of each step comes from a logarithmic resolution code R, so one PWM cycle always takes 2^(R+1) beats while the phase word keeps its full 16-bit span. Only the top R+1 phase bits carry information.

The per-channel logic uses three outputs. It compares duty and delay values against the phase. It uses the beat strobe to pace blink or ramp effects. It uses the cycle-start strobe to mark the beginning of each PWM period. The surrounding configuration logic normally comes out of reset with the divider at 0x8000, the resolution at 7 and the counter disabled. It then drives those values on the configuration inputs.

Top module: `pwm_timebase`

## Requirements
- R1: While `rstN` is low, `phase` is 0 and `beatStb` and `cycleStart` are 0.
- R2: With `cntEn` sampled low at a clock edge, after that edge `phase` is 0, both strobes are 0, and the prescaler restarts from zero.
- R3: With divider value D, `beatStb` is a one-clock pulse every D+1 clocks. If `cntEn` is first sampled high at edge k, the first pulse is high in the cycle after edge k+D.
- R4: On every beat, `phase` increases by 2^(15-R), modulo 2^16. R is the `resCode` sampled at that beat's edge, and any value above 15 is treated as 15.
- R5: `cycleStart` is high for exactly those beats on which the phase addition wraps past 2^16. It is never high without `beatStb`.
- R6: With D and R held constant after enable, `cycleStart` first appears 2^(R+1)·(D+1) clocks after enable. It then repeats every 2^(R+1)·(D+1) clocks.
- R7: A new `clkDiv` value is taken only at a beat boundary. The beat in progress completes with the old length, and the following beats use the new one.
- R8: Between beats, `phase` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Counter enable; low clears phase and prescaler |
| clkDiv | input | 27 | Beat length minus one, in clock periods |
| resCode | input | 4 | Logarithmic resolution code R |
| phase | output | 16 | Current phase in units of 2^-16 cycle |
| beatStb | output | 1 | One-clock pulse per beat |
| cycleStart | output | 1 | One-clock pulse on the beat where phase wraps |

## Verification
The step-size and wrap properties take `resCode` as the value sampled at the updating edge. They hold however R changes, because the wrap is defined by the carry and not by the phase landing exactly on zero. The exact cycle-start period in R6 holds only when R stays constant from enable onward, because a mid-cycle R change leaves the phase unaligned. For this reason the stimulus changes R or D only while disabled, except in the divider-change scenario, which holds R constant. The bench sweeps every divider from 0 to 3 against every R from 0 to 6 over two full cycles. It then runs R=15 through a complete 65536-beat cycle and covers mid-run divider changes in both directions.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  // Strobes passed from the prescaler control to the phase datapath
  typedef struct packed {
    logic beat;   // this clock edge closes a beat
    logic clear;  // counter disabled: force datapath to zero
  } tickCtrl_t;
endpackage

// File: rtl/pwm_timebase_prescale.sv
module pwm_timebase_prescale
  import pwm_timebase_pkg::*;
#(
  parameter int DIV_W = 27
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic [DIV_W-1:0] clkDiv,
  output tickCtrl_t        ctrl
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;   // divider captured at a beat boundary
  logic             atEnd;

  assign atEnd      = (divCnt == divLim);
  assign ctrl.beat  = cntEn && atEnd;
  assign ctrl.clear = !cntEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      divLim <= '0;
    end else if (!cntEn) begin
      divCnt <= '0;
      divLim <= clkDiv;
    end else if (atEnd) begin
      divCnt <= '0;
      divLim <= clkDiv;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_timebase_phase.sv
module pwm_timebase_phase
  import pwm_timebase_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int RES_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickCtrl_t        ctrl,
  input  logic [RES_W-1:0] resCode,
  output logic [PH_W-1:0]  phase,
  output logic             beatStb,
  output logic             cycleStart
);
  localparam int MAX_RES = PH_W - 1;

  logic [RES_W-1:0] resEff;
  logic [PH_W-1:0]  step;
  logic [PH_W:0]    sum;

  always_comb begin
    if (int'(resCode) > MAX_RES) resEff = RES_W'(MAX_RES);
    else                         resEff = resCode;
  end

  // one-hot step: bit (MAX_RES - resEff)
  for (genvar i = 0; i < PH_W; i++) begin : g_step
    assign step[i] = (int'(resEff) == MAX_RES - i);
  end

  assign sum = {1'b0, phase} + {1'b0, step};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= '0;
      beatStb    <= 1'b0;
      cycleStart <= 1'b0;
    end else if (ctrl.clear) begin
      phase      <= '0;
      beatStb    <= 1'b0;
      cycleStart <= 1'b0;
    end else if (ctrl.beat) begin
      phase      <= sum[PH_W-1:0];
      beatStb    <= 1'b1;
      cycleStart <= sum[PH_W];
    end else begin
      beatStb    <= 1'b0;
      cycleStart <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int DIV_W = 27,
  parameter int RES_W = 4,
  parameter int PH_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [RES_W-1:0] resCode,
  output logic [PH_W-1:0]  phase,
  output logic             beatStb,
  output logic             cycleStart
);
  tickCtrl_t ctrl;

  pwm_timebase_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk    (clk),
    .rstN   (rstN),
    .cntEn  (cntEn),
    .clkDiv (clkDiv),
    .ctrl   (ctrl)
  );

  pwm_timebase_phase #(.PH_W(PH_W), .RES_W(RES_W)) u_phase (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .resCode    (resCode),
    .phase      (phase),
    .beatStb    (beatStb),
    .cycleStart (cycleStart)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int RES_W = 4,
  parameter int PH_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic [RES_W-1:0] resCode,
  input logic [PH_W-1:0]  phase,
  input logic             beatStb,
  input logic             cycleStart
);
  function automatic logic [PH_W-1:0] stepOf(logic [RES_W-1:0] r);
    int e;
    e = (int'(r) > PH_W - 1) ? PH_W - 1 : int'(r);
    return PH_W'(1) << (PH_W - 1 - e);
  endfunction

  // R2
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> (phase == '0 && !beatStb && !cycleStart));

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatStb |-> (PH_W'(phase - $past(phase)) == stepOf($past(resCode))));

  // R5
  cycle_on_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |-> beatStb);

  // R5
  cycle_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatStb |-> (cycleStart == (phase < $past(phase))));

  // R8
  hold_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!beatStb && $past(cntEn)) |-> $stable(phase));
endmodule

bind pwm_timebase pwm_timebase_chk #(.RES_W(RES_W), .PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cntEn      (cntEn),
  .resCode    (resCode),
  .phase      (phase),
  .beatStb    (beatStb),
  .cycleStart (cycleStart)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic [26:0] clkDiv = '0;
  logic [3:0]  resCode = '0;
  logic [15:0] phase;
  logic        beatStb;
  logic        cycleStart;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  pwm_timebase u_pwm_timebase (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .clkDiv(clkDiv),
    .resCode(resCode), .phase(phase), .beatStb(beatStb),
    .cycleStart(cycleStart)
  );

  task automatic chk(string tag, int expPh, bit expBeat, bit expCyc);
    checks++;
    if (phase !== 16'(expPh) || beatStb !== expBeat || cycleStart !== expCyc) begin
      failures++;
      $display("FAIL %s: phase/beat/cyc got %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, phase, beatStb, cycleStart, expPh & 16'hffff, expBeat, expCyc);
    end
  endtask

  task automatic chkInt(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Enable with constant D and R, compare every cycle to the arithmetic model
  task automatic runCfg(int d, int r, int nCyc);
    int step, period, lastCyc, beats;
    bit expBeat;
    int expPh;
    @(negedge clk);
    cntEn = 1'b0; clkDiv = 27'(d); resCode = 4'(r);
    @(negedge clk); @(negedge clk);
    chk("R2 idle while disabled", 0, 0, 0);
    cntEn = 1'b1;
    step = 1 << (15 - r);
    period = (1 << (r + 1)) * (d + 1);
    lastCyc = -1;
    for (int n = 0; n < nCyc; n++) begin
      @(negedge clk);
      beats   = (n + 1) / (d + 1);
      expBeat = ((n + 1) % (d + 1)) == 0;
      expPh   = (beats * step) % 65536;
      chk($sformatf("R3 R4 R5 R8 d=%0d r=%0d n=%0d", d, r, n),
          expPh, expBeat, expBeat && expPh == 0);
      if (cycleStart) begin
        if (lastCyc < 0) chkInt($sformatf("R6 first cycle d=%0d r=%0d", d, r), n, period - 1);
        else             chkInt($sformatf("R6 cycle gap d=%0d r=%0d", d, r), n - lastCyc, period);
        lastCyc = n;
      end
    end
  endtask

  initial begin
    #(190000 * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int beats, expPh;
    bit expBeat;
    // R1: reset holds outputs low even with enable high
    cntEn = 1'b1; clkDiv = 27'd0; resCode = 4'd7;
    repeat (3) @(negedge clk);
    chk("R1 during reset", 0, 0, 0);
    cntEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset release, disabled", 0, 0, 0);

    // Sweep D and R
    for (int d = 0; d < 4; d++)
      for (int r = 0; r < 7; r++)
        runCfg(d, r, 2 * (1 << (r + 1)) * (d + 1) + 3);

    // Finest resolution: a full 65536-beat cycle
    runCfg(0, 15, 65540);

    // R2: disable in the middle of a run
    runCfg(2, 3, 10);
    @(negedge clk);   // nothing driven; next edge still enabled
    cntEn = 1'b0;
    @(negedge clk);
    chk("R2 mid-run disable clears", 0, 0, 0);
    repeat (3) begin @(negedge clk); chk("R2 stays cleared", 0, 0, 0); end

    // R7: shorten divider mid-beat (3 -> 0), R=3 step 4096
    @(negedge clk);
    clkDiv = 27'd3; resCode = 4'd3;
    @(negedge clk);
    cntEn = 1'b1;
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      beats   = (n < 3) ? 0 : n - 2;
      expBeat = (n >= 3);
      expPh   = (beats * 4096) % 65536;
      chk($sformatf("R7 shorten n=%0d", n), expPh, expBeat, expBeat && expPh == 0);
      if (n == 1) clkDiv = 27'd0;
    end

    // R7: lengthen divider (0 -> 4), R=2 step 8192
    @(negedge clk);
    cntEn = 1'b0; clkDiv = 27'd0; resCode = 4'd2;
    @(negedge clk);
    cntEn = 1'b1;
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      if (n <= 3) begin beats = n + 1; expBeat = 1'b1; end
      else begin beats = 4 + (n - 3) / 5; expBeat = ((n - 3) % 5) == 0; end
      expPh = (beats * 8192) % 65536;
      chk($sformatf("R7 lengthen n=%0d", n), expPh, expBeat, expBeat && expPh == 0);
      if (n == 2) clkDiv = 27'd4;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule